// File: doc/BRIEF.md
# Device Control and Status Register for a PCI Express Function

This block holds the 32-bit device control and status word of one PCI Express function. Configuration software writes it through a configuration-space write port. A local management bus writes it through a second, independent port. The control fields go straight out as level outputs: the error-reporting enables, the max payload and max read request size codes, and the relaxed-ordering, no-snoop and extended-tag enables.

The upper half of the word holds four sticky error-detected flags. Detection event inputs set these flags whether or not reporting is enabled, and only a write of one clears them. The block also turns each detection event into a one-cycle message request, but only when that class's reporting enable is set. A write of one to the function-level reset bit produces a one-cycle reset pulse. A transaction-pending input is mirrored into a read-only bit. Unused feature bits are tied to zero.

Top module: `pcie_devctl_reg`

## Requirements
- R1: After reset the read word is 0x0000_2910 when `txn_pending` is 0. Every enable is 0, the max payload code is 0, the max read request code is 2, and relaxed ordering, extended tag and no-snoop are 1.
- R2: A configuration write loads bits 0-8 and 11-14 from the write data, and the new value is visible on the edge that takes the write. Bits 3:0 are the reporting enables for {unsupported, fatal, non-fatal, correctable}, from bit 3 down to bit 0. Bit 4 is relaxed ordering. Bits 7:5 are the payload code. Bit 8 is extended tag. Bit 11 is no-snoop. Bits 14:12 are the read request code.
- R3: A management write loads the same bits in the same way. When both ports write in one cycle, the configuration data wins for these bits.
- R4: Bits 9, 10, 15, 20 and 31:22 always read 0.
- R5: Writing 1 to bit 15 from either port raises `flr_pulse` for exactly the one cycle after the write edge. The pulse does not clear any configuration field.
- R6: A high on `evt[i]` sets status bit 16+i on the next edge, whatever the enables are. `evt` is ordered {unsupported, fatal, non-fatal, correctable} from bit 3 down to bit 0. The bit then holds.
- R7: Writing 1 to bit 16+i from either port clears that status bit. Writing 0 leaves it unchanged. Clear requests from both ports in the same cycle combine.
- R8: When a detection event and a clear hit the same status bit in the same cycle, the bit stays 1.
- R9: `msg_req[i]` is 1 for the cycle after an edge where `evt[i]` was high and enable bit i was 1 before that edge. It is 0 otherwise.
- R10: Bit 21 follows `txn_pending` combinationally.
- R11: The control outputs always equal their fields in the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration-space write strobe |
| cfg_wdata | input | 32 | Configuration-space write data |
| mgmt_we | input | 1 | Management bus write strobe |
| mgmt_wdata | input | 32 | Management bus write data |
| evt | input | 4 | Error detection events {unsupported, fatal, non-fatal, correctable} |
| txn_pending | input | 1 | Non-posted requests outstanding |
| rdata | output | 32 | Current register word |
| flr_pulse | output | 1 | Function-level reset pulse |
| msg_req | output | 4 | Error message requests, same order as `evt` |
| err_report_en | output | 4 | Reporting enables, same order as `evt` |
| max_payload_code | output | 3 | Max payload size code |
| max_rdreq_code | output | 3 | Max read request size code |
| relaxed_order_en | output | 1 | Relaxed ordering enable |
| no_snoop_en | output | 1 | No-snoop enable |
| ext_tag_en | output | 1 | Extended tag enable |

## Verification
Writes, status set and clear, `flr_pulse` and `msg_req` all appear on the first clock edge after the stimulus. Bit 21 is combinational and follows `txn_pending` at once. The bench applies each stimulus on a falling edge and removes it on the next falling edge. It samples every registered result on that next falling edge, one full edge after the stimulus. It checks pulse outputs again one falling edge later to show they have returned to zero.

// File: rtl/pcie_devctl_reg.sv
module pcie_devctl_reg #(
  parameter int NUM_ERR = 4,
  parameter int CODE_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [31:0]         cfg_wdata,
  input  logic                mgmt_we,
  input  logic [31:0]         mgmt_wdata,
  input  logic [NUM_ERR-1:0]  evt,
  input  logic                txn_pending,
  output logic [31:0]         rdata,
  output logic                flr_pulse,
  output logic [NUM_ERR-1:0]  msg_req,
  output logic [NUM_ERR-1:0]  err_report_en,
  output logic [CODE_W-1:0]   max_payload_code,
  output logic [CODE_W-1:0]   max_rdreq_code,
  output logic                relaxed_order_en,
  output logic                no_snoop_en,
  output logic                ext_tag_en
);

  localparam int STAT_LO = 16;
  localparam int STAT_HI = STAT_LO + NUM_ERR - 1;
  localparam int FLR_BIT = 15;
  localparam logic [CODE_W-1:0] MRRS_RST = CODE_W'(2);

  logic [NUM_ERR-1:0] en_q, det_q, msg_q, clr;
  logic               ro_q, et_q, ns_q, flr_q, any_we, flr_req;
  logic [CODE_W-1:0]  mps_q, mrrs_q;
  logic [31:0]        wd;

  assign any_we  = cfg_we | mgmt_we;
  assign wd      = cfg_we ? cfg_wdata : mgmt_wdata;
  assign clr     = ({NUM_ERR{cfg_we}}  & cfg_wdata[STAT_HI:STAT_LO])
                 | ({NUM_ERR{mgmt_we}} & mgmt_wdata[STAT_HI:STAT_LO]);
  assign flr_req = (cfg_we & cfg_wdata[FLR_BIT]) | (mgmt_we & mgmt_wdata[FLR_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      ro_q   <= 1'b1;
      mps_q  <= '0;
      et_q   <= 1'b1;
      ns_q   <= 1'b1;
      mrrs_q <= MRRS_RST;
      det_q  <= '0;
      flr_q  <= 1'b0;
      msg_q  <= '0;
    end else begin
      if (any_we) begin
        en_q   <= wd[NUM_ERR-1:0];
        ro_q   <= wd[4];
        mps_q  <= wd[5 +: CODE_W];
        et_q   <= wd[8];
        ns_q   <= wd[11];
        mrrs_q <= wd[12 +: CODE_W];
      end
      det_q <= (det_q & ~clr) | evt;
      flr_q <= flr_req;
      msg_q <= evt & en_q;
    end
  end

  assign rdata = {10'b0, txn_pending, 1'b0, det_q, 1'b0, mrrs_q, ns_q, 2'b00,
                  et_q, mps_q, ro_q, en_q};

  assign flr_pulse        = flr_q;
  assign msg_req          = msg_q;
  assign err_report_en    = en_q;
  assign max_payload_code = mps_q;
  assign max_rdreq_code   = mrrs_q;
  assign relaxed_order_en = ro_q;
  assign no_snoop_en      = ns_q;
  assign ext_tag_en       = et_q;

  a_r4_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & 32'hFFD0_8600) == 32'h0);

  a_r5_flr_single: assert property (@(posedge clk) disable iff (!rst_n)
    flr_pulse |=> !flr_pulse);

  a_r5_flr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flr_pulse |-> $past((cfg_we && cfg_wdata[15]) || (mgmt_we && mgmt_wdata[15])));

  a_r6_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    |evt |=> ((rdata[19:16] & $past(evt)) == $past(evt)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[16] && !(cfg_we && cfg_wdata[16]) && !(mgmt_we && mgmt_wdata[16])) |=> rdata[16]);

  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    |msg_req |-> ((msg_req & ~$past(evt & rdata[3:0])) == 4'b0));

  a_r10_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[21] == txn_pending);

  a_r11_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    max_payload_code == rdata[7:5] && max_rdreq_code == rdata[14:12] &&
    err_report_en == rdata[3:0] && ext_tag_en == rdata[8]);

endmodule

// File: tb/test_pcie_devctl_reg.sv
module test_pcie_devctl_reg;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, mgmt_we = 0, txn_pending = 0;
  logic [31:0] cfg_wdata = 0, mgmt_wdata = 0;
  logic [3:0]  evt = 0;
  logic [31:0] rdata;
  logic        flr_pulse, relaxed_order_en, no_snoop_en, ext_tag_en;
  logic [3:0]  msg_req, err_report_en;
  logic [2:0]  max_payload_code, max_rdreq_code;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pcie_devctl_reg i_pcie_devctl_reg (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .mgmt_we, .mgmt_wdata, .evt, .txn_pending,
    .rdata, .flr_pulse, .msg_req, .err_report_en, .max_payload_code,
    .max_rdreq_code, .relaxed_order_en, .no_snoop_en, .ext_tag_en);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic cw, input logic [31:0] cd, input logic mw,
                      input logic [31:0] md, input logic [3:0] e);
    cfg_we = cw; cfg_wdata = cd; mgmt_we = mw; mgmt_wdata = md; evt = e;
    @(negedge clk);
    cfg_we = 0; mgmt_we = 0; evt = 0;
  endtask

  task automatic t_reset;
    chk("R1 word", rdata, 32'h0000_2910);
    chk("R1 outs", {err_report_en, 1'b0, max_payload_code, 1'b0, max_rdreq_code,
        relaxed_order_en, ext_tag_en, no_snoop_en, flr_pulse, msg_req},
        {4'h0, 1'b0, 3'd0, 1'b0, 3'd2, 3'b111, 1'b0, 4'h0});
  endtask

  task automatic t_cfg_write;
    step(1, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R2 all ones", rdata, 32'h0000_79FF);
    chk("R4 zero bits", rdata & 32'hFFD0_8600, 0);
    chk("R11 codes", {max_payload_code, max_rdreq_code}, {3'd7, 3'd7});
    step(1, 32'h0, 0, 0, 0);
    chk("R2 zeros", rdata, 0);
    chk("R11 enables", {relaxed_order_en, no_snoop_en, ext_tag_en, err_report_en}, 0);
    step(1, 32'h0000_50A5, 0, 0, 0);
    chk("R2 pattern", rdata, 32'h0000_50A5);
    chk("R11 pattern", {max_payload_code, max_rdreq_code, err_report_en}, {3'd5, 3'd5, 4'h5});
  endtask

  task automatic t_mgmt_write;
    step(0, 0, 1, 32'hFFFF_2912, 0);
    chk("R3 mgmt", rdata, 32'h0000_2912);
    step(1, 32'h0000_0003, 1, 32'h0000_7800, 0);
    chk("R3 cfg wins", rdata, 32'h0000_0003);
  endtask

  task automatic t_flr;
    step(1, 32'h0000_F9FF, 0, 0, 0);
    chk("R5 pulse cfg", {31'b0, flr_pulse}, 1);
    chk("R4 bit15 reads 0", rdata, 32'h0000_79FF);
    @(negedge clk);
    chk("R5 pulse ends", {31'b0, flr_pulse}, 0);
    chk("R5 fields kept", rdata, 32'h0000_79FF);
    step(0, 0, 1, 32'h0000_8000, 0);
    chk("R5 pulse mgmt", {31'b0, flr_pulse}, 1);
    @(negedge clk);
    chk("R5 pulse mgmt ends", {31'b0, flr_pulse}, 0);
  endtask

  task automatic t_status;
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 4'b0001);
    chk("R6 cor set", rdata, 32'h0001_0000);
    chk("R9 disabled no msg", {28'b0, msg_req}, 0);
    step(0, 0, 0, 0, 4'b1110);
    chk("R6 all set", rdata, 32'h000F_0000);
    repeat (3) @(negedge clk);
    chk("R6 sticky", rdata, 32'h000F_0000);
  endtask

  task automatic t_clear;
    step(1, 32'h0001_0000, 0, 0, 0);
    chk("R7 cfg clear", rdata, 32'h000E_0000);
    step(0, 0, 1, 32'h0004_0000, 0);
    chk("R7 mgmt clear", rdata, 32'h000A_0000);
    step(1, 32'h0000_0000, 0, 0, 0);
    chk("R7 zero no effect", rdata, 32'h000A_0000);
    step(1, 32'h0002_0000, 1, 32'h0008_0000, 0);
    chk("R7 both combine", rdata, 0);
    step(0, 0, 0, 0, 4'b0100);
    step(1, 32'h0004_0000, 0, 0, 4'b0100);
    chk("R8 event wins", rdata, 32'h0004_0000);
    step(1, 32'h0004_0000, 0, 0, 0);
    chk("R7 then cleared", rdata, 0);
  endtask

  task automatic t_msg;
    step(1, 32'h0000_0005, 0, 0, 0);
    step(0, 0, 0, 0, 4'b1111);
    chk("R9 gated", {28'b0, msg_req}, 32'h5);
    @(negedge clk);
    chk("R9 one cycle", {28'b0, msg_req}, 0);
    step(1, 32'h000F_000F, 0, 0, 0);
    step(0, 0, 0, 0, 4'b1000);
    chk("R9 unsupported", {28'b0, msg_req}, 32'h8);
    chk("R6 with enable", rdata, 32'h0008_000F);
  endtask

  task automatic t_pending;
    txn_pending = 1; #1;
    chk("R10 high", {31'b0, rdata[21]}, 1);
    txn_pending = 0; #1;
    chk("R10 low", {31'b0, rdata[21]}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cfg_write();
    t_mgmt_write();
    t_flr();
    t_status();
    t_clear();
    t_msg();
    t_pending();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule